// File: doc/BRIEF.md
# Single-Cycle Instruction Control Decoder

This block turns the operation code and function code of a 32-bit instruction into the full set of control lines that steer a single-cycle processor datapath for one clock. It is purely combinational: the operation code (instruction bits 31:26), the function code (bits 5:0) and the ALU zero flag go in, and the same cycle yields the next-PC choice, the two ALU operand choices, the register write address and data choices, the immediate extension mode, the 5-bit ALU function, the two write enables and an illegal-instruction flag for the exception path.

The ALU function code is the concatenation {subtract, boolean/shift mode[1:0], shift, arithmetic}. The A operand can be register rs, the shift amount field, or the constant 16. Load-upper-immediate uses the constant 16 with a left shift of the immediate. The write address can be rd, rt or register 31. The block has no data stream and no handshake: every pin is a plain level, and any control that a rule below does not name for an instruction is driven 0.

Top module: `insn_ctrl_decoder`

## Requirements
- R1: With opcode 0, funct 100000/100001 give alu_fn 00001 (add) and 100010/100011 give 10001 (subtract); 100100, 100101, 100110 and 100111 give 00000, 00100, 01000 and 01100 (and, or, xor, nor); all set rf_we=1, wa_sel=0 (rd), wd_sel=1 (ALU), a_sel=0, b_sel=0, sext_en=0.
- R2: With opcode 0, constant shifts 000000/000010/000011 select a_sel=1 (shamt field) and variable shifts 000100/000110/000111 select a_sel=0 (rs); left, logical right and arithmetic right use alu_fn 00010, 01010 and 01110; b_sel=0, rf_we=1, wa_sel=0, wd_sel=1.
- R3: With opcode 0, funct 101010 gives alu_fn 10011 (signed less-than) and 101011 gives 10111 (unsigned less-than), writing the ALU result to rd with register operands.
- R4: Opcodes 001000 to 001110 set b_sel=1, rf_we=1, wa_sel=1 (rt), wd_sel=1; alu_fn is 00001, 00001, 10011, 10111, 00000, 00100, 01000 in that opcode order; sext_en is 1 for 001000 to 001011 and 0 for 001100 to 001110.
- R5: Opcode 001111 (load upper) sets a_sel=2 (constant 16), b_sel=1, alu_fn=00010, sext_en=0, rf_we=1, wa_sel=1, wd_sel=1.
- R6: Opcode 100011 (load) sets b_sel=1, sext_en=1, alu_fn=00001, rf_we=1, wa_sel=1, wd_sel=2 (memory); opcode 101011 (store) sets b_sel=1, sext_en=1, alu_fn=00001, mem_we=1, rf_we=0.
- R7: Opcodes 000100 (branch if equal) and 000101 (branch if not equal) set alu_fn=10001, sext_en=1, b_sel=0 and no writes; pc_sel is 1 when the branch is taken (equal: alu_zero=1, not equal: alu_zero=0) and 0 otherwise.
- R8: Opcode 000010 sets pc_sel=2 with no writes; opcode 000011 sets pc_sel=2, rf_we=1, wa_sel=2 (register 31), wd_sel=0 (PC+4).
- R9: With opcode 0, funct 001000 sets pc_sel=3 (register target) with no writes; funct 001001 sets pc_sel=3, rf_we=1, wa_sel=0, wd_sel=0.
- R10: Every opcode and every opcode-0 funct not listed above sets illegal_op=1 with all other outputs 0 (no register or memory write, pc_sel=0); every listed encoding sets illegal_op=0.
- R11: pc_sel is 0 for every instruction outside the branch and jump rules, and mem_we is 1 only for the store opcode.
- R12: For any nonzero opcode the funct input has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode | input | 6 | Instruction bits 31:26 |
| funct | input | 6 | Instruction bits 5:0 |
| alu_zero | input | 1 | ALU result-is-zero flag for branch resolution |
| pc_sel | output | 2 | 0 PC+4, 1 branch target, 2 jump target, 3 register rs |
| a_sel | output | 2 | 0 rs, 1 shift amount field, 2 constant 16 |
| b_sel | output | 1 | 0 register rt, 1 extended immediate |
| wa_sel | output | 2 | 0 rd, 1 rt, 2 register 31 |
| wd_sel | output | 2 | 0 PC+4, 1 ALU result, 2 memory read data |
| sext_en | output | 1 | 1 sign-extends the immediate, 0 zero-extends |
| alu_fn | output | 5 | {sub, mode[1:0], shift, arith} |
| rf_we | output | 1 | Register file write enable |
| mem_we | output | 1 | Data memory write enable |
| illegal_op | output | 1 | Unrecognised encoding |

## Verification
The bench builds the decoder with its package field widths at their defaults: 6-bit operation and function codes and a 5-bit ALU function. At that size the whole input space is 64 opcodes by 64 function codes by both zero-flag values, 8192 points, so every point is applied and every output field is compared against a model written from the requirements. That reaches every illegal hole in both code spaces, the taken and not-taken side of both branches, and the funct bits under every nonzero opcode.

// File: rtl/scdec_pkg.sv
package scdec_pkg;

  localparam int OP_W   = 6;
  localparam int FN_W   = 6;
  localparam int ALUF_W = 5;
  localparam int SEL_W  = 2;

  typedef enum logic [SEL_W-1:0] {
    PC_SEQ    = 2'd0,
    PC_BRANCH = 2'd1,
    PC_JUMP   = 2'd2,
    PC_REG    = 2'd3
  } pc_sel_e;

  typedef enum logic [SEL_W-1:0] {
    A_RS    = 2'd0,
    A_SHAMT = 2'd1,
    A_K16   = 2'd2
  } a_sel_e;

  typedef enum logic [SEL_W-1:0] {
    W_RD  = 2'd0,
    W_RT  = 2'd1,
    W_R31 = 2'd2
  } wa_sel_e;

  typedef enum logic [SEL_W-1:0] {
    D_LINK = 2'd0,
    D_ALU  = 2'd1,
    D_MEM  = 2'd2
  } wd_sel_e;

  // Control-flow class, resolved to a PC choice with the zero flag
  typedef enum logic [2:0] {
    FL_SEQ  = 3'd0,
    FL_BEQ  = 3'd1,
    FL_BNE  = 3'd2,
    FL_JUMP = 3'd3,
    FL_REG  = 3'd4
  } flow_e;

  // ALU function: {sub, mode[1:0], shift, arith}
  localparam logic [ALUF_W-1:0] FN_ADD  = 5'b00001;
  localparam logic [ALUF_W-1:0] FN_SUB  = 5'b10001;
  localparam logic [ALUF_W-1:0] FN_LT   = 5'b10011;
  localparam logic [ALUF_W-1:0] FN_LTU  = 5'b10111;
  localparam logic [ALUF_W-1:0] FN_SHL  = 5'b00010;
  localparam logic [ALUF_W-1:0] FN_SHR  = 5'b01010;
  localparam logic [ALUF_W-1:0] FN_SHRA = 5'b01110;
  localparam logic [ALUF_W-1:0] FN_AND  = 5'b00000;
  localparam logic [ALUF_W-1:0] FN_OR   = 5'b00100;
  localparam logic [ALUF_W-1:0] FN_XOR  = 5'b01000;
  localparam logic [ALUF_W-1:0] FN_NOR  = 5'b01100;

  // Operation codes
  localparam logic [OP_W-1:0] OPC_REG   = 6'b000000;
  localparam logic [OP_W-1:0] OPC_JMP   = 6'b000010;
  localparam logic [OP_W-1:0] OPC_JLNK  = 6'b000011;
  localparam logic [OP_W-1:0] OPC_BEQ   = 6'b000100;
  localparam logic [OP_W-1:0] OPC_BNE   = 6'b000101;
  localparam logic [OP_W-1:0] OPC_ADDI  = 6'b001000;
  localparam logic [OP_W-1:0] OPC_ADDIU = 6'b001001;
  localparam logic [OP_W-1:0] OPC_LTI   = 6'b001010;
  localparam logic [OP_W-1:0] OPC_LTIU  = 6'b001011;
  localparam logic [OP_W-1:0] OPC_ANDI  = 6'b001100;
  localparam logic [OP_W-1:0] OPC_ORI   = 6'b001101;
  localparam logic [OP_W-1:0] OPC_XORI  = 6'b001110;
  localparam logic [OP_W-1:0] OPC_UPPER = 6'b001111;
  localparam logic [OP_W-1:0] OPC_LOAD  = 6'b100011;
  localparam logic [OP_W-1:0] OPC_STORE = 6'b101011;

  // Function codes under OPC_REG
  localparam logic [FN_W-1:0] FC_SHL   = 6'b000000;
  localparam logic [FN_W-1:0] FC_SHR   = 6'b000010;
  localparam logic [FN_W-1:0] FC_SHRA  = 6'b000011;
  localparam logic [FN_W-1:0] FC_SHLV  = 6'b000100;
  localparam logic [FN_W-1:0] FC_SHRV  = 6'b000110;
  localparam logic [FN_W-1:0] FC_SHRAV = 6'b000111;
  localparam logic [FN_W-1:0] FC_JREG  = 6'b001000;
  localparam logic [FN_W-1:0] FC_JRLNK = 6'b001001;
  localparam logic [FN_W-1:0] FC_ADD   = 6'b100000;
  localparam logic [FN_W-1:0] FC_ADDU  = 6'b100001;
  localparam logic [FN_W-1:0] FC_SUB   = 6'b100010;
  localparam logic [FN_W-1:0] FC_SUBU  = 6'b100011;
  localparam logic [FN_W-1:0] FC_AND   = 6'b100100;
  localparam logic [FN_W-1:0] FC_OR    = 6'b100101;
  localparam logic [FN_W-1:0] FC_XOR   = 6'b100110;
  localparam logic [FN_W-1:0] FC_NOR   = 6'b100111;
  localparam logic [FN_W-1:0] FC_LT    = 6'b101010;
  localparam logic [FN_W-1:0] FC_LTU   = 6'b101011;

  typedef struct packed {
    flow_e               flow;
    a_sel_e              a_sel;
    logic                b_imm;
    wa_sel_e             wa_sel;
    wd_sel_e             wd_sel;
    logic                sext;
    logic [ALUF_W-1:0]   alu_fn;
    logic                rf_we;
    logic                mem_we;
  } ctrl_t;

  localparam ctrl_t CTRL_NONE = '0;

endpackage

// File: rtl/scdec_rfunc.sv
module scdec_rfunc
  import scdec_pkg::*;
(
  input  logic [FN_W-1:0] funct,
  output ctrl_t           ctl,
  output logic            hit
);

  always_comb begin
    ctl        = CTRL_NONE;
    hit        = 1'b1;
    ctl.wa_sel = W_RD;
    ctl.wd_sel = D_ALU;
    ctl.rf_we  = 1'b1;
    case (funct)
      FC_ADD, FC_ADDU: ctl.alu_fn = FN_ADD;
      FC_SUB, FC_SUBU: ctl.alu_fn = FN_SUB;
      FC_AND:          ctl.alu_fn = FN_AND;
      FC_OR:           ctl.alu_fn = FN_OR;
      FC_XOR:          ctl.alu_fn = FN_XOR;
      FC_NOR:          ctl.alu_fn = FN_NOR;
      FC_LT:           ctl.alu_fn = FN_LT;
      FC_LTU:          ctl.alu_fn = FN_LTU;
      FC_SHL: begin
        ctl.a_sel  = A_SHAMT;
        ctl.alu_fn = FN_SHL;
      end
      FC_SHR: begin
        ctl.a_sel  = A_SHAMT;
        ctl.alu_fn = FN_SHR;
      end
      FC_SHRA: begin
        ctl.a_sel  = A_SHAMT;
        ctl.alu_fn = FN_SHRA;
      end
      FC_SHLV:  ctl.alu_fn = FN_SHL;
      FC_SHRV:  ctl.alu_fn = FN_SHR;
      FC_SHRAV: ctl.alu_fn = FN_SHRA;
      FC_JREG: begin
        ctl.flow   = FL_REG;
        ctl.wd_sel = D_LINK;
        ctl.rf_we  = 1'b0;
      end
      FC_JRLNK: begin
        ctl.flow   = FL_REG;
        ctl.wd_sel = D_LINK;
      end
      default: begin
        ctl = CTRL_NONE;
        hit = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/scdec_opcode.sv
module scdec_opcode
  import scdec_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  output ctrl_t           ctl,
  output logic            hit,
  output logic            reg_form
);

  assign reg_form = (opcode == OPC_REG);

  always_comb begin
    ctl = CTRL_NONE;
    hit = 1'b1;
    case (opcode)
      OPC_REG: hit = 1'b1;
      OPC_ADDI, OPC_ADDIU, OPC_LTI, OPC_LTIU,
      OPC_ANDI, OPC_ORI, OPC_XORI: begin
        ctl.b_imm  = 1'b1;
        ctl.wa_sel = W_RT;
        ctl.wd_sel = D_ALU;
        ctl.rf_we  = 1'b1;
        ctl.sext   = ~opcode[2];
        case (opcode)
          OPC_LTI:  ctl.alu_fn = FN_LT;
          OPC_LTIU: ctl.alu_fn = FN_LTU;
          OPC_ANDI: ctl.alu_fn = FN_AND;
          OPC_ORI:  ctl.alu_fn = FN_OR;
          OPC_XORI: ctl.alu_fn = FN_XOR;
          default:  ctl.alu_fn = FN_ADD;
        endcase
      end
      OPC_UPPER: begin
        ctl.a_sel  = A_K16;
        ctl.b_imm  = 1'b1;
        ctl.alu_fn = FN_SHL;
        ctl.wa_sel = W_RT;
        ctl.wd_sel = D_ALU;
        ctl.rf_we  = 1'b1;
      end
      OPC_LOAD: begin
        ctl.b_imm  = 1'b1;
        ctl.sext   = 1'b1;
        ctl.alu_fn = FN_ADD;
        ctl.wa_sel = W_RT;
        ctl.wd_sel = D_MEM;
        ctl.rf_we  = 1'b1;
      end
      OPC_STORE: begin
        ctl.b_imm  = 1'b1;
        ctl.sext   = 1'b1;
        ctl.alu_fn = FN_ADD;
        ctl.mem_we = 1'b1;
      end
      OPC_BEQ, OPC_BNE: begin
        ctl.sext   = 1'b1;
        ctl.alu_fn = FN_SUB;
        ctl.flow   = opcode[0] ? FL_BNE : FL_BEQ;
      end
      OPC_JMP: ctl.flow = FL_JUMP;
      OPC_JLNK: begin
        ctl.flow   = FL_JUMP;
        ctl.wa_sel = W_R31;
        ctl.wd_sel = D_LINK;
        ctl.rf_we  = 1'b1;
      end
      default: hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/scdec_flow.sv
module scdec_flow
  import scdec_pkg::*;
(
  input  flow_e   flow,
  input  logic    zero,
  output pc_sel_e pc_sel
);

  always_comb begin
    case (flow)
      FL_BEQ:  pc_sel = zero  ? PC_BRANCH : PC_SEQ;
      FL_BNE:  pc_sel = !zero ? PC_BRANCH : PC_SEQ;
      FL_JUMP: pc_sel = PC_JUMP;
      FL_REG:  pc_sel = PC_REG;
      default: pc_sel = PC_SEQ;
    endcase
  end

endmodule

// File: rtl/insn_ctrl_decoder.sv
module insn_ctrl_decoder
  import scdec_pkg::*;
(
  input  logic [OP_W-1:0]   opcode,
  input  logic [FN_W-1:0]   funct,
  input  logic              alu_zero,
  output logic [SEL_W-1:0]  pc_sel,
  output logic [SEL_W-1:0]  a_sel,
  output logic              b_sel,
  output logic [SEL_W-1:0]  wa_sel,
  output logic [SEL_W-1:0]  wd_sel,
  output logic              sext_en,
  output logic [ALUF_W-1:0] alu_fn,
  output logic              rf_we,
  output logic              mem_we,
  output logic              illegal_op
);

  ctrl_t   rf_ctl, op_ctl, sel_ctl;
  logic    rf_hit, op_hit, reg_form, legal;
  pc_sel_e pc_next;

  scdec_rfunc u_rfunc (
    .funct (funct),
    .ctl   (rf_ctl),
    .hit   (rf_hit)
  );

  scdec_opcode u_opcode (
    .opcode   (opcode),
    .ctl      (op_ctl),
    .hit      (op_hit),
    .reg_form (reg_form)
  );

  always_comb begin
    legal   = reg_form ? rf_hit : op_hit;
    sel_ctl = reg_form ? rf_ctl : op_ctl;
    if (!legal) sel_ctl = CTRL_NONE;
  end

  scdec_flow u_flow (
    .flow   (sel_ctl.flow),
    .zero   (alu_zero),
    .pc_sel (pc_next)
  );

  assign pc_sel     = pc_next;
  assign a_sel      = sel_ctl.a_sel;
  assign b_sel      = sel_ctl.b_imm;
  assign wa_sel     = sel_ctl.wa_sel;
  assign wd_sel     = sel_ctl.wd_sel;
  assign sext_en    = sel_ctl.sext;
  assign alu_fn     = sel_ctl.alu_fn;
  assign rf_we      = sel_ctl.rf_we;
  assign mem_we     = sel_ctl.mem_we;
  assign illegal_op = !legal;

  always_comb begin
    if (!$isunknown({opcode, funct, alu_zero})) begin
      a_r10_illegal_quiet: assert (!(illegal_op && (rf_we || mem_we || pc_sel != 2'd0)));
      a_r6_single_write: assert (!(rf_we && mem_we));
      a_r9_reg_target_regform: assert (pc_sel != 2'd3 || opcode == 6'd0);
      a_r5_k16_with_imm: assert (a_sel != 2'd2 || (b_sel && wa_sel == 2'd1 && opcode != 6'd0));
      a_r7_taken_branch_no_write: assert (pc_sel != 2'd1 || (!rf_we && !mem_we && alu_fn == 5'b10001));
      a_r2_shamt_regform: assert (a_sel != 2'd1 || opcode == 6'd0);
    end
  end

endmodule

// File: tb/insn_ctrl_decoder_tb.sv
module insn_ctrl_decoder_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = '0;
  logic [5:0] funct = '0;
  logic       alu_zero = 1'b0;
  logic [1:0] pc_sel, a_sel, wa_sel, wd_sel;
  logic       b_sel, sext_en, rf_we, mem_we, illegal_op;
  logic [4:0] alu_fn;

  int n_checks = 0;
  int n_errors = 0;
  int cyc = 0;
  int cur_op, cur_fn, cur_z;

  // expected values
  int e_pc, e_a, e_b, e_wa, e_wd, e_sx, e_fn, e_rf, e_mem, e_ill;
  string e_tag;

  always #4 clk = ~clk;

  insn_ctrl_decoder u_dut (
    .opcode(opcode), .funct(funct), .alu_zero(alu_zero),
    .pc_sel(pc_sel), .a_sel(a_sel), .b_sel(b_sel), .wa_sel(wa_sel),
    .wd_sel(wd_sel), .sext_en(sext_en), .alu_fn(alu_fn),
    .rf_we(rf_we), .mem_we(mem_we), .illegal_op(illegal_op)
  );

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_errors++;
      $display("FAIL watchdog expired: act=%0d exp<=150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s op=%0d fn=%0d z=%0d act=%0d exp=%0d",
               tag, what, cur_op, cur_fn, cur_z, act, exp);
    end
  endtask

  task automatic rcls(string t, int fn, int a);
    e_tag = t; e_fn = fn; e_a = a;
    e_rf = 1; e_wa = 0; e_wd = 1;
  endtask

  // Reference model built from the requirement text
  task automatic model(int op, int fn, int z);
    e_pc = 0; e_a = 0; e_b = 0; e_wa = 0; e_wd = 0; e_sx = 0;
    e_fn = 0; e_rf = 0; e_mem = 0; e_ill = 0; e_tag = "R10";
    if (op == 0) begin
      case (fn)
        32, 33: rcls("R1", 1, 0);
        34, 35: rcls("R1", 17, 0);
        36: rcls("R1", 0, 0);
        37: rcls("R1", 4, 0);
        38: rcls("R1", 8, 0);
        39: rcls("R1", 12, 0);
        0: rcls("R2", 2, 1);
        2: rcls("R2", 10, 1);
        3: rcls("R2", 14, 1);
        4: rcls("R2", 2, 0);
        6: rcls("R2", 10, 0);
        7: rcls("R2", 14, 0);
        42: rcls("R3", 19, 0);
        43: rcls("R3", 23, 0);
        8: begin e_tag = "R9"; e_pc = 3; end
        9: begin e_tag = "R9"; e_pc = 3; e_rf = 1; e_wa = 0; e_wd = 0; end
        default: e_ill = 1;
      endcase
    end else begin
      case (op)
        8, 9, 10, 11, 12, 13, 14: begin
          e_tag = "R4"; e_b = 1; e_rf = 1; e_wa = 1; e_wd = 1;
          e_sx = (op <= 11) ? 1 : 0;
          case (op)
            10: e_fn = 19;
            11: e_fn = 23;
            12: e_fn = 0;
            13: e_fn = 4;
            14: e_fn = 8;
            default: e_fn = 1;
          endcase
        end
        15: begin e_tag = "R5"; e_a = 2; e_b = 1; e_fn = 2; e_rf = 1; e_wa = 1; e_wd = 1; end
        35: begin e_tag = "R6"; e_b = 1; e_sx = 1; e_fn = 1; e_rf = 1; e_wa = 1; e_wd = 2; end
        43: begin e_tag = "R6"; e_b = 1; e_sx = 1; e_fn = 1; e_mem = 1; end
        4:  begin e_tag = "R7"; e_fn = 17; e_sx = 1; e_pc = (z == 1) ? 1 : 0; end
        5:  begin e_tag = "R7"; e_fn = 17; e_sx = 1; e_pc = (z == 0) ? 1 : 0; end
        2:  begin e_tag = "R8"; e_pc = 2; end
        3:  begin e_tag = "R8"; e_pc = 2; e_rf = 1; e_wa = 2; e_wd = 0; end
        default: e_ill = 1;
      endcase
      if (fn != 0) e_tag = "R12";
    end
  endtask

  task automatic compare_all();
    string pt, mt;
    model(cur_op, cur_fn, cur_z);
    pt = (e_tag == "R7" || e_tag == "R8" || e_tag == "R9") ? e_tag : "R11";
    mt = (e_tag == "R12") ? "R12" : "R11";
    chk(e_tag, "illegal_op", int'(illegal_op), e_ill);
    chk(pt,    "pc_sel",     int'(pc_sel),     e_pc);
    chk(e_tag, "a_sel",      int'(a_sel),      e_a);
    chk(e_tag, "b_sel",      int'(b_sel),      e_b);
    chk(e_tag, "wa_sel",     int'(wa_sel),     e_wa);
    chk(e_tag, "wd_sel",     int'(wd_sel),     e_wd);
    chk(e_tag, "sext_en",    int'(sext_en),    e_sx);
    chk(e_tag, "alu_fn",     int'(alu_fn),     e_fn);
    chk(e_tag, "rf_we",      int'(rf_we),      e_rf);
    chk(mt,    "mem_we",     int'(mem_we),     e_mem);
  endtask

  initial begin
    // Reset state: all-zero inputs decode as a constant left shift (R2)
    repeat (3) @(posedge clk);
    @(negedge clk);
    cur_op = 0; cur_fn = 0; cur_z = 0;
    chk("R2", "reset alu_fn", int'(alu_fn), 2);
    chk("R2", "reset a_sel",  int'(a_sel),  1);
    rst = 1'b0;

    // Exhaustive sweep: R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 R12
    for (int op = 0; op < 64; op++) begin
      for (int fn = 0; fn < 64; fn++) begin
        for (int z = 0; z < 2; z++) begin
          @(posedge clk);
          opcode   <= 6'(op);
          funct    <= 6'(fn);
          alu_zero <= z[0];
          @(negedge clk);
          cur_op = op; cur_fn = fn; cur_z = z;
          compare_all();
        end
      end
    end

    summary();
    $finish;
  end

endmodule